// File: doc/BRIEF.md
# Flash bus fault pattern tester

This block checks the wiring between a controller and a byte-wide flash. It has two phases. First it writes a fixed pattern over the whole address space through a simple write request port. Then it reads back the two extreme addresses, lowest and highest, one after the other, for a set number of rounds. Every read-back byte is compared with the pattern value for that address. The pattern places a distinct marker byte at each address that a single broken address line would redirect a read to. So when a read returns the wrong byte, that byte usually names the line that failed.

Each mismatch is logged on an error output with the address, the expected byte and the returned byte. It is also classified as one of three kinds: a specific address line, a specific data bit, or unclassified. Per-line and per-bit fault totals are kept in saturating counters. A host pulses `start`, waits for `done`, and then reads the totals. Stress control, erase and program command sequences are left to the surrounding logic, which answers the request ports.

Top module: `flash_bus_prober`

## Requirements
- R1: After reset, `wr_req`, `rd_req`, `done` and `err_valid` are low and every fault counter reads zero.
- R2: A `start` pulse begins a write phase. `wr_addr` steps upward by one from 0 to the all-ones address. Each address and its byte are held until `wr_ack` is sampled high with `wr_req`. `rd_req` stays low until the all-ones write has been acknowledged.
- R3: Pattern values are as follows.
  - Address 0 holds 0xFF, and the all-ones address holds 0x00.
  - An address with only bit i set, and an address with only bit i clear, both hold marker i. The markers for i = 0 to 21 are 07,0B,0D,0E,16,1A,1C,1F,25,29,2C,2F,34,38,3D,3E,43,49,4A,4F,52,58.
  - Every other address holds entry (number of set address bits mod 6) of the list 33,55,66,99,AA,CC, indexed 0 to 5.
- R4: The read phase issues reads at address 0 and the all-ones address in strict alternation, starting at address 0. It moves to the next address only after `rd_ack`.
- R5: A read whose `rd_data` differs from the pattern byte makes `err_valid` high for exactly one cycle, in the cycle after the acknowledge. `err_addr`, `err_exp` and `err_act` carry the address, the expected byte and the returned byte. A matching read raises no error.
- R6: A mismatch whose returned byte equals marker i is reported with `err_kind` = 1 and `err_index` = i, and address-line counter i is incremented.
- R7: Any other mismatch that differs from the expected byte in exactly one bit position b is reported with `err_kind` = 2 and `err_index` = b, and data-bit counter b is incremented.
- R8: All remaining mismatches are reported with `err_kind` = 3 and leave every counter unchanged.
- R9: Each counter is CW bits wide and stops at 2^CW-1; it never wraps.
- R10: `done` rises one cycle after the acknowledge of the all-ones read that completes round number `iter_limit`. If `iter_limit` is 0, it instead rises one cycle after the last write is acknowledged. While `done` is high, no request is issued.
- R11: `start` is honoured only while idle or done. It clears all counters and restarts the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new test run |
| iter_limit | input | ITW | Number of bottom/top read rounds |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Pattern byte to write |
| wr_ack | input | 1 | Write accepted |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 8 | Returned byte |
| err_valid | output | 1 | One-cycle mismatch report |
| err_addr | output | AW | Address of the mismatch |
| err_exp | output | 8 | Expected byte |
| err_act | output | 8 | Returned byte |
| err_kind | output | 2 | 1 address line, 2 data bit, 3 unclassified |
| err_index | output | IDX_W | Line or bit number |
| pin_faults | output | AW*CW | Address-line counters, line i at bits i*CW |
| bit_faults | output | 8*CW | Data-bit counters, bit b at bits b*CW |
| done | output | 1 | Run complete |

## Verification
A memory model answers the write and read ports with irregular acknowledge gaps. The bench runs the read phase under four kinds of corruption, each telling apart a different classification path:
- **Clean replies:** prove that no error is raised on a healthy bus.
- **Redirected reads:** the model returns the byte one flipped address line away, which must be reported as that line from both end addresses.
- **Single flipped data bit:** repeated long enough to drive a counter into saturation.
- **Multi-bit corruption:** must be reported without touching any counter.

A run with zero rounds checks the early finish. Restarting after a faulty run checks that the counters clear.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  localparam int BW = 8;

  localparam logic [1:0] FK_NONE  = 2'd0;
  localparam logic [1:0] FK_ADDR  = 2'd1;
  localparam logic [1:0] FK_DATA  = 2'd2;
  localparam logic [1:0] FK_OTHER = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ, PH_DONE} phase_e;

  // marker byte naming address line i
  function automatic logic [7:0] line_marker(input int unsigned i);
    case (i)
      0: return 8'h07;  1: return 8'h0B;  2: return 8'h0D;  3: return 8'h0E;
      4: return 8'h16;  5: return 8'h1A;  6: return 8'h1C;  7: return 8'h1F;
      8: return 8'h25;  9: return 8'h29; 10: return 8'h2C; 11: return 8'h2F;
     12: return 8'h34; 13: return 8'h38; 14: return 8'h3D; 15: return 8'h3E;
     16: return 8'h43; 17: return 8'h49; 18: return 8'h4A; 19: return 8'h4F;
     20: return 8'h52; 21: return 8'h58;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fill_byte(input int unsigned j);
    case (j)
      0: return 8'h33;
      1: return 8'h55;
      2: return 8'h66;
      3: return 8'h99;
      4: return 8'hAA;
      default: return 8'hCC;
    endcase
  endfunction
endpackage

// File: rtl/fbt_pattern_gen.sv
module fbt_pattern_gen
  import fbt_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    pattern
);
  logic [AW-1:0] lo_hit, hi_hit;

  // one-hot and one-cold address detectors per line
  for (genvar gi = 0; gi < AW; gi++) begin : g_line
    assign lo_hit[gi] = (addr == (AW'(1) << gi));
    assign hi_hit[gi] = (addr == ~(AW'(1) << gi));
  end

  int unsigned ones;
  logic        marker_hit;
  logic [7:0]  marker_val;

  always_comb begin
    ones       = 0;
    marker_hit = 1'b0;
    marker_val = 8'h00;
    for (int i = 0; i < AW; i++) begin
      ones = ones + {31'd0, addr[i]};
      if (lo_hit[i] || hi_hit[i]) begin
        marker_hit = 1'b1;
        marker_val = line_marker(i);
      end
    end
    if (addr == '0)
      pattern = 8'hFF;
    else if (&addr)
      pattern = 8'h00;
    else if (marker_hit)
      pattern = marker_val;
    else
      pattern = fill_byte(ones % 6);
  end
endmodule

// File: rtl/fbt_classifier.sv
module fbt_classifier
  import fbt_pkg::*;
#(
  parameter int AW    = 22,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       exp_b,
  input  logic [7:0]       act_b,
  output logic [1:0]       kind,
  output logic [IDX_W-1:0] index
);
  logic [7:0]       diff;
  int unsigned      nflip;
  logic             line_found;
  logic [IDX_W-1:0] line_idx, bit_idx;

  always_comb begin
    diff       = exp_b ^ act_b;
    nflip      = 0;
    line_found = 1'b0;
    line_idx   = '0;
    bit_idx    = '0;
    for (int i = 0; i < AW; i++) begin
      if (act_b == line_marker(i)) begin
        line_found = 1'b1;
        line_idx   = IDX_W'(i);
      end
    end
    for (int j = 0; j < 8; j++) begin
      nflip = nflip + {31'd0, diff[j]};
      if (diff[j]) bit_idx = IDX_W'(j);
    end
    if (diff == 8'h00) begin
      kind  = FK_NONE;
      index = '0;
    end else if (line_found) begin
      kind  = FK_ADDR;
      index = line_idx;
    end else if (nflip == 1) begin
      kind  = FK_DATA;
      index = bit_idx;
    end else begin
      kind  = FK_OTHER;
      index = '0;
    end
  end
endmodule

// File: rtl/fbt_fault_counters.sv
module fbt_fault_counters #(
  parameter int N     = 8,
  parameter int CW    = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [IDX_W-1:0] idx,
  output logic [N*CW-1:0]  counts
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  for (genvar gi = 0; gi < N; gi++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        cnt_q <= '0;
      else if (inc && idx == IDX_W'(gi) && cnt_q != CMAX)
        cnt_q <= cnt_q + CW'(1);
    end
    assign counts[gi*CW +: CW] = cnt_q;

    // R9: a full counter holds its value until cleared
    p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CMAX && !clr) |=> cnt_q == CMAX);
  end
endmodule

// File: rtl/flash_bus_prober.sv
module flash_bus_prober
  import fbt_pkg::*;
#(
  parameter  int AW    = 22,
  parameter  int CW    = 16,
  parameter  int ITW   = 16,
  localparam int IDX_W = ($clog2(AW) > 3) ? $clog2(AW) : 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ITW-1:0]    iter_limit,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              err_valid,
  output logic [AW-1:0]     err_addr,
  output logic [7:0]        err_exp,
  output logic [7:0]        err_act,
  output logic [1:0]        err_kind,
  output logic [IDX_W-1:0]  err_index,
  output logic [AW*CW-1:0]  pin_faults,
  output logic [8*CW-1:0]   bit_faults,
  output logic              done
);
  phase_e         phase_q;
  logic [AW-1:0]  addr_q, addr_nxt;
  logic [7:0]     byte_q, byte_nxt;
  logic [ITW-1:0] iter_q;

  logic wr_fire, rd_fire, go;
  assign wr_fire = (phase_q == PH_WRITE) && wr_ack;
  assign rd_fire = (phase_q == PH_READ) && rd_ack;
  assign go      = start && (phase_q == PH_IDLE || phase_q == PH_DONE);

  // next address: step while writing, flip between ends while reading
  always_comb begin
    addr_nxt = addr_q;
    if (go)           addr_nxt = '0;
    else if (wr_fire) addr_nxt = addr_q + AW'(1);
    else if (rd_fire) addr_nxt = ~addr_q;
  end

  fbt_pattern_gen #(.AW(AW)) u_pat (
    .addr    (addr_nxt),
    .pattern (byte_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
      iter_q  <= '0;
    end else begin
      addr_q <= addr_nxt;
      byte_q <= byte_nxt;
      case (phase_q)
        PH_IDLE, PH_DONE: begin
          if (go) begin
            phase_q <= PH_WRITE;
            iter_q  <= '0;
          end
        end
        PH_WRITE: begin
          if (wr_fire && &addr_q)
            phase_q <= (iter_limit == '0) ? PH_DONE : PH_READ;
        end
        PH_READ: begin
          if (rd_fire && &addr_q) begin
            iter_q <= iter_q + ITW'(1);
            if (iter_q + ITW'(1) == iter_limit) phase_q <= PH_DONE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign wr_req  = (phase_q == PH_WRITE);
  assign rd_req  = (phase_q == PH_READ);
  assign done    = (phase_q == PH_DONE);
  assign wr_addr = addr_q;
  assign rd_addr = addr_q;
  assign wr_data = byte_q;

  logic [1:0]       cls_kind;
  logic [IDX_W-1:0] cls_idx;
  logic             mism;

  fbt_classifier #(.AW(AW), .IDX_W(IDX_W)) u_cls (
    .exp_b (byte_q),
    .act_b (rd_data),
    .kind  (cls_kind),
    .index (cls_idx)
  );

  assign mism = rd_fire && (cls_kind != FK_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
      err_exp   <= '0;
      err_act   <= '0;
      err_kind  <= FK_NONE;
      err_index <= '0;
    end else begin
      err_valid <= mism;
      if (mism) begin
        err_addr  <= addr_q;
        err_exp   <= byte_q;
        err_act   <= rd_data;
        err_kind  <= cls_kind;
        err_index <= cls_idx;
      end
    end
  end

  fbt_fault_counters #(.N(AW), .CW(CW), .IDX_W(IDX_W)) u_line_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (go),
    .inc    (mism && cls_kind == FK_ADDR),
    .idx    (cls_idx),
    .counts (pin_faults)
  );

  fbt_fault_counters #(.N(8), .CW(CW), .IDX_W(IDX_W)) u_bit_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (go),
    .inc    (mism && cls_kind == FK_DATA),
    .idx    (cls_idx),
    .counts (bit_faults)
  );

  // R2: reads begin only right after the top write is accepted
  p_read_after_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !$past(rd_req)) |-> $past(wr_req && wr_ack && &wr_addr));

  // R2: an accepted write moves to the next address
  p_write_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ack && !(&wr_addr)) |=> (wr_req && wr_addr == $past(wr_addr) + AW'(1)));

  // R2: an unaccepted write holds address and byte
  p_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R4: each accepted read moves to the opposite end
  p_read_alternate_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> rd_addr == ~$past(rd_addr));

  // R5: a report only follows an accepted read with wrong data
  p_err_after_bad_read_r5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(rd_req && rd_ack && rd_data != wr_data));

  // R10: done is entered only from the last accepted transfer
  p_done_entry_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past((rd_req && rd_ack && &rd_addr) || (wr_req && wr_ack && &wr_addr)));
endmodule

// File: tb/flash_bus_prober_test.sv
`timescale 1ns/1ps
module flash_bus_prober_test;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int ITW = 8;
  localparam int IDX_W = 3;
  localparam int NADDR = 1 << AW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ITW-1:0] iter_limit = '0;
  logic wr_req, rd_req, done, err_valid;
  logic [AW-1:0] wr_addr, rd_addr, err_addr;
  logic [7:0] wr_data, err_exp, err_act;
  logic wr_ack = 1'b0;
  logic rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [1:0] err_kind;
  logic [IDX_W-1:0] err_index;
  logic [AW*CW-1:0] pin_faults;
  logic [8*CW-1:0] bit_faults;

  flash_bus_prober #(.AW(AW), .CW(CW), .ITW(ITW)) uut (
    .clk(clk), .rst(rst), .start(start), .iter_limit(iter_limit),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .err_valid(err_valid), .err_addr(err_addr), .err_exp(err_exp),
    .err_act(err_act), .err_kind(err_kind), .err_index(err_index),
    .pin_faults(pin_faults), .bit_faults(bit_faults), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] marker(input int i);
    case (i)
      0: return 8'h07; 1: return 8'h0B; 2: return 8'h0D; 3: return 8'h0E;
      4: return 8'h16; 5: return 8'h1A; 6: return 8'h1C; default: return 8'h1F;
    endcase
  endfunction

  function automatic logic [7:0] filler(input int j);
    case (j)
      0: return 8'h33; 1: return 8'h55; 2: return 8'h66;
      3: return 8'h99; 4: return 8'hAA; default: return 8'hCC;
    endcase
  endfunction

  // R3 pattern computed from the requirement text
  function automatic logic [7:0] ref_pat(input logic [AW-1:0] a);
    int ones = 0;
    int setpos = 0;
    int clrpos = 0;
    for (int i = 0; i < AW; i++) begin
      if (a[i]) begin ones++; setpos = i; end
      else clrpos = i;
    end
    if (ones == 0) return 8'hFF;
    if (ones == AW) return 8'h00;
    if (ones == 1) return marker(setpos);
    if (ones == AW - 1) return marker(clrpos);
    return filler(ones % 6);
  endfunction

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0] e;
    logic [7:0] v;
    logic [1:0] k;
    logic [IDX_W-1:0] ix;
  } err_item_t;

  err_item_t pend[$];
  logic [7:0] mem [NADDR];
  int exp_pin [AW];
  int exp_bit [8];
  int fmode = 0;
  int fsel = 0;
  int wexp = 0;
  int rd_count = 0;
  bit rd_top = 0;
  int cyc = 0;

  function automatic string kind_req(input logic [1:0] k);
    if (k == 2'd1) return "R6";
    if (k == 2'd2) return "R7";
    return "R8";
  endfunction

  // memory model, fault injector, scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (pend.size() > 0) begin
        err_item_t it;
        it = pend.pop_front();
        chk(err_valid == 1'b1, "R5", "err_valid after bad read", 32'(err_valid), 32'd1);
        chk(err_addr == it.a, "R5", "err_addr", 32'(err_addr), 32'(it.a));
        chk(err_exp == it.e, "R5", "err_exp", 32'(err_exp), 32'(it.e));
        chk(err_act == it.v, "R5", "err_act", 32'(err_act), 32'(it.v));
        chk(err_kind == it.k, kind_req(it.k), "err_kind", 32'(err_kind), 32'(it.k));
        chk(err_index == it.ix, kind_req(it.k), "err_index", 32'(err_index), 32'(it.ix));
      end else if (err_valid) begin
        chk(1'b0, "R5", "unexpected err_valid", 32'd1, 32'd0);
      end

      wr_ack = 1'b0;
      rd_ack = 1'b0;
      if (wr_req && (cyc % 3 != 2)) begin
        chk(32'(wr_addr) == wexp, "R2", "write order", 32'(wr_addr), 32'(wexp));
        mem[wr_addr] = wr_data;
        wexp++;
        wr_ack = 1'b1;
      end
      if (rd_req) begin
        if (wexp != NADDR) chk(1'b0, "R2", "read before fill done", 32'(wexp), 32'(NADDR));
        if (cyc % 4 != 3) begin
          logic [7:0] ev, av;
          logic [AW-1:0] want;
          want = rd_top ? {AW{1'b1}} : '0;
          chk(rd_addr == want, "R4", "read address", 32'(rd_addr), 32'(want));
          ev = ref_pat(rd_addr);
          case (fmode)
            1: av = mem[rd_addr ^ (AW'(1) << fsel)];
            2: av = mem[rd_addr] ^ (8'h01 << fsel);
            3: av = mem[rd_addr] ^ 8'h81;
            default: av = mem[rd_addr];
          endcase
          rd_data = av;
          rd_ack = 1'b1;
          rd_top = !rd_top;
          rd_count++;
          if (av != ev) begin
            err_item_t ni;
            logic [7:0] d;
            int nb, bp, lp;
            d = av ^ ev;
            nb = 0; bp = 0; lp = -1;
            for (int j = 0; j < 8; j++) if (d[j]) begin nb++; bp = j; end
            for (int i = 0; i < AW; i++) if (av == marker(i)) lp = i;
            ni.a = rd_addr; ni.e = ev; ni.v = av;
            if (lp >= 0) begin
              ni.k = 2'd1; ni.ix = IDX_W'(lp);
              if (exp_pin[lp] < CMAX) exp_pin[lp]++;
            end else if (nb == 1) begin
              ni.k = 2'd2; ni.ix = IDX_W'(bp);
              if (exp_bit[bp] < CMAX) exp_bit[bp]++;
            end else begin
              ni.k = 2'd3; ni.ix = '0;
            end
            pend.push_back(ni);
          end
        end
      end
    end
    cyc++;
  end

  task automatic check_counters(input string req);
    for (int i = 0; i < AW; i++)
      chk(int'(pin_faults[i*CW +: CW]) == exp_pin[i], req, $sformatf("line counter %0d", i),
          32'(pin_faults[i*CW +: CW]), 32'(exp_pin[i]));
    for (int b = 0; b < 8; b++)
      chk(int'(bit_faults[b*CW +: CW]) == exp_bit[b], req, $sformatf("bit counter %0d", b),
          32'(bit_faults[b*CW +: CW]), 32'(exp_bit[b]));
  endtask

  task automatic run_test(input int iters, input int mode, input int sel, input string cnt_req);
    fmode = mode;
    fsel = sel;
    wexp = 0;
    rd_top = 0;
    rd_count = 0;
    for (int i = 0; i < AW; i++) exp_pin[i] = 0;
    for (int b = 0; b < 8; b++) exp_bit[b] = 0;
    @(negedge clk);
    iter_limit = ITW'(iters);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_counters("R11");
    while (!done) @(negedge clk);
    chk(wexp == NADDR, "R2", "writes in fill phase", 32'(wexp), 32'(NADDR));
    chk(rd_count == 2 * iters, "R10", "reads before done", 32'(rd_count), 32'(2 * iters));
    for (int a = 0; a < NADDR; a++)
      chk(mem[a] == ref_pat(AW'(a)), "R3", $sformatf("pattern at %0h", a),
          32'(mem[a]), 32'(ref_pat(AW'(a))));
    repeat (10) @(negedge clk);
    chk(rd_count == 2 * iters, "R10", "no reads after done", 32'(rd_count), 32'(2 * iters));
    chk(!rd_req && !wr_req && done, "R10", "quiet while done",
        32'({rd_req, wr_req, done}), 32'h1);
    chk(pend.size() == 0, "R5", "pending reports", 32'(pend.size()), 32'd0);
    check_counters(cnt_req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_req && !rd_req && !done && !err_valid, "R1", "idle outputs after reset",
        32'({wr_req, rd_req, done, err_valid}), 32'd0);
    chk(pin_faults == '0 && bit_faults == '0, "R1", "counters after reset",
        32'(|pin_faults), 32'd0);
    run_test(3, 0, 0, "R5");   // clean bus
    run_test(2, 1, 5, "R6");   // line 5 redirects both ends
    run_test(10, 2, 6, "R9");  // bit 6 flips, counter saturates
    chk(int'(bit_faults[6*CW +: CW]) == CMAX, "R9", "saturated bit counter",
        32'(bit_faults[6*CW +: CW]), 32'(CMAX));
    run_test(2, 3, 0, "R8");   // multi-bit corruption, no counts
    run_test(0, 0, 0, "R10");  // zero rounds
    run_test(1, 2, 0, "R7");   // single data bit 0
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule